// File: doc/BRIEF.md
# Masked Packed Saturating Subtractor

This block is a SIMD datapath stage. It subtracts each unsigned lane of one 512-bit operand from the matching lane of another. A lane whose true difference would be negative is clamped to zero instead of wrapping. Lanes are 8 or 16 bits wide. The active vector length is 128, 256 or 512 bits, so 16 to 64 byte lanes or 8 to 32 word lanes take part.

Three operand styles are supported:

- **Legacy two-operand style.** The current destination value acts as the minuend. The width is fixed at 128 bits, and everything above bit 127 passes through unchanged.
- **Three-operand style.** Separate sources are subtracted. Destination bits above the active length are cleared.
- **Masked style.** Like the three-operand style, but a per-lane mask decides which lanes receive the difference. An unselected lane either keeps its old destination contents (merge) or becomes zero (zeroing).

The result is registered on an input strobe and presented one cycle later with a valid flag. No flags and no exceptions are produced.

Top module: `psub_sat_unit`

## Requirements
- R1: In byte mode (`lane_word`=0), each 8-bit lane outputs first-minuend minus `src_b` when that is not negative, and 8'h00 when `src_b` is larger.
- R2: In word mode (`lane_word`=1), each 16-bit lane clamps to 16'h0000 on underflow. No borrow ever crosses a lane boundary; for example, 16'h0100 minus 16'h0001 gives 16'h00FF.
- R3: In the three-operand style (`enc_sel`=1) and the masked style (`enc_sel`=2), `vlen_sel` sets the active length: 0 selects 128 bits, 1 selects 256 bits and 2 selects 512 bits. Every `dest_out` bit at or above that length is zero.
- R4: In the masked style with `mask_en`=1, lane j takes the clamped difference when `mask_bits[j]`=1. Lane j covers bits j*8 and up in byte mode, and bits j*16 and up in word mode.
- R5: In the masked style with `mask_en`=1 and `mask_zero`=0, an active lane whose mask bit is 0 keeps its `dest_in` value (merge).
- R6: In the masked style with `mask_en`=1 and `mask_zero`=1, an active lane whose mask bit is 0 becomes zero.
- R7: When `mask_en`=0, or in the legacy or three-operand styles, `mask_bits` has no effect and every active lane takes the difference.
- R8: Mask bits at or above the active lane count have no effect on `dest_out`.
- R9: In the legacy style (`enc_sel`=0), the minuend is `dest_in` and `src_a` is ignored. The length is 128 bits, and `dest_out[511:128]` equals `dest_in[511:128]`.
- R10: Illegal selections fall back as follows: `enc_sel`=3 acts as the legacy style; a legacy selection with any `vlen_sel` acts as 128 bits; `vlen_sel`=3 acts as 128 bits.
- R11: `dest_out` and `out_valid` update on the clock edge after a cycle with `in_valid`=1. `out_valid` is 1 for exactly that one cycle, and `dest_out` holds while `in_valid`=0.
- R12: A synchronous active-high `rst` clears `dest_out` and `out_valid` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation strobe |
| dest_in | input | 512 | Prior destination value; also the minuend in the legacy style |
| src_a | input | 512 | Minuend in the three-operand and masked styles |
| src_b | input | 512 | Subtrahend |
| lane_word | input | 1 | 0 = byte lanes, 1 = 16-bit lanes |
| vlen_sel | input | 2 | Active length: 0 = 128, 1 = 256, 2 = 512, 3 = treated as 128 |
| enc_sel | input | 2 | Operand style: 0 = legacy, 1 = three-operand, 2 = masked, 3 = treated as legacy |
| mask_bits | input | 64 | Per-lane write mask |
| mask_en | input | 1 | Enables the write mask in the masked style |
| mask_zero | input | 1 | 1 = zero unselected lanes, 0 = merge them |
| out_valid | output | 1 | Result valid, one cycle after the strobe |
| dest_out | output | 512 | New destination value |

## Verification
Operands are drawn from a hash, so that across all lanes the minuend is sometimes above and sometimes below the subtrahend. Both clamping and exact differences are therefore hit in byte and word mode, and a misplaced borrow or a wrong lane width shows up. Directed values isolate the cases where a correct word result differs from two byte results, such as 16'h0100 minus 16'h0001.

Each operand style is run at each length with patterned masks, which separates:

- a wrong vector-length boundary;
- merge versus zero behaviour;
- legacy pass-through of the upper bits versus clearing.

Paired runs that differ only in `src_a`, in the mask bits above the lane count, or in `mask_en`, show whether an input that must be ignored leaks into the result.

// File: rtl/psub_pkg.sv
package psub_pkg;

    typedef enum logic [1:0] {
        VL_128  = 2'd0,
        VL_256  = 2'd1,
        VL_512  = 2'd2,
        VL_RSVD = 2'd3
    } vlen_e;

    typedef enum logic [1:0] {
        ENC_LEGACY = 2'd0,
        ENC_THREE  = 2'd1,
        ENC_MASKED = 2'd2,
        ENC_RSVD   = 2'd3
    } enc_e;

    localparam int BYTE_W = 8;
    localparam int WORD_W = 16;

endpackage

// File: rtl/psub_lane_sat.sv
module psub_lane_sat #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] res
);
    logic [W:0] wide_d;

    always_comb begin
        wide_d = {1'b0, a} - {1'b0, b};
        res    = wide_d[W] ? '0 : wide_d[W-1:0];
        // R1/R2: a clamped unsigned difference never exceeds the minuend
        p_clamp_le_minuend_r1: assert (res <= a);
    end
endmodule

// File: rtl/psub_lane_array.sv
module psub_lane_array #(
    parameter int DATA_W = 512,
    parameter int LANE_W = 8
) (
    input  logic [DATA_W-1:0] a_vec,
    input  logic [DATA_W-1:0] b_vec,
    output logic [DATA_W-1:0] d_vec
);
    localparam int NL = DATA_W / LANE_W;

    // one independent subtractor per lane: no carry chain across lanes
    for (genvar i = 0; i < NL; i++) begin : g_lane
        psub_lane_sat #(.W(LANE_W)) u_sat (
            .a   (a_vec[i*LANE_W +: LANE_W]),
            .b   (b_vec[i*LANE_W +: LANE_W]),
            .res (d_vec[i*LANE_W +: LANE_W])
        );
    end
endmodule

// File: rtl/psub_byte_ctrl.sv
module psub_byte_ctrl
    import psub_pkg::*;
#(
    parameter int DATA_W = 512
) (
    input  logic              lane_word,
    input  logic [1:0]        vlen_sel,
    input  logic [1:0]        enc_sel,
    input  logic [DATA_W/8-1:0] mask_bits,
    input  logic              mask_en,
    input  logic              mask_zero,
    output logic              legacy,
    output logic [DATA_W/8-1:0] take_res,
    output logic [DATA_W/8-1:0] keep_old
);
    localparam int NB = DATA_W / 8;

    logic       masked_d;
    logic [7:0] act_bytes_d;

    always_comb begin
        legacy   = (enc_sel == ENC_LEGACY) || (enc_sel == ENC_RSVD);
        masked_d = (enc_sel == ENC_MASKED) && mask_en;
        if (legacy) begin
            act_bytes_d = 8'd16;
        end else begin
            case (vlen_sel)
                VL_256:  act_bytes_d = 8'd32;
                VL_512:  act_bytes_d = 8'd64;
                default: act_bytes_d = 8'd16;
            endcase
        end
    end

    for (genvar bi = 0; bi < NB; bi++) begin : g_byte
        localparam int LANE_B = bi;
        localparam int LANE_H = bi / 2;
        logic in_rng_d;
        logic off_d;
        always_comb begin
            in_rng_d = (8'(bi) < act_bytes_d);
            off_d    = masked_d &&
                       !(lane_word ? mask_bits[LANE_H] : mask_bits[LANE_B]);
            take_res[bi] = in_rng_d && !off_d;
            keep_old[bi] = legacy ? !in_rng_d
                                  : (in_rng_d && off_d && !mask_zero);
            // a byte is never both written and preserved
            p_action_exclusive_r5: assert (!(take_res[bi] && keep_old[bi]));
        end
    end
endmodule

// File: rtl/psub_sat_unit.sv
module psub_sat_unit
    import psub_pkg::*;
#(
    parameter int DATA_W = 512,
    localparam int MASK_W = DATA_W / BYTE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] dest_in,
    input  logic [DATA_W-1:0] src_a,
    input  logic [DATA_W-1:0] src_b,
    input  logic              lane_word,
    input  logic [1:0]        vlen_sel,
    input  logic [1:0]        enc_sel,
    input  logic [MASK_W-1:0] mask_bits,
    input  logic              mask_en,
    input  logic              mask_zero,
    output logic              out_valid,
    output logic [DATA_W-1:0] dest_out
);
    localparam int NB = DATA_W / 8;

    typedef struct packed {
        logic              valid;
        logic [DATA_W-1:0] data;
    } st_t;

    st_t st_d, st_q;

    logic              legacy;
    logic [NB-1:0]     take_res;
    logic [NB-1:0]     keep_old;
    logic [DATA_W-1:0] minuend_d;
    logic [DATA_W-1:0] bdiff;
    logic [DATA_W-1:0] wdiff;
    logic [DATA_W-1:0] result_d;

    psub_byte_ctrl #(.DATA_W(DATA_W)) u_ctrl (
        .lane_word (lane_word),
        .vlen_sel  (vlen_sel),
        .enc_sel   (enc_sel),
        .mask_bits (mask_bits),
        .mask_en   (mask_en),
        .mask_zero (mask_zero),
        .legacy    (legacy),
        .take_res  (take_res),
        .keep_old  (keep_old)
    );

    assign minuend_d = legacy ? dest_in : src_a;

    psub_lane_array #(.DATA_W(DATA_W), .LANE_W(BYTE_W)) u_bytes (
        .a_vec (minuend_d),
        .b_vec (src_b),
        .d_vec (bdiff)
    );

    psub_lane_array #(.DATA_W(DATA_W), .LANE_W(WORD_W)) u_words (
        .a_vec (minuend_d),
        .b_vec (src_b),
        .d_vec (wdiff)
    );

    always_comb begin
        for (int b = 0; b < NB; b++) begin
            if (take_res[b])
                result_d[b*8 +: 8] = lane_word ? wdiff[b*8 +: 8] : bdiff[b*8 +: 8];
            else if (keep_old[b])
                result_d[b*8 +: 8] = dest_in[b*8 +: 8];
            else
                result_d[b*8 +: 8] = 8'h00;
        end
        st_d = st_q;
        st_d.valid = in_valid;
        if (in_valid)
            st_d.data = result_d;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign out_valid = st_q.valid;
    assign dest_out  = st_q.data;

    p_valid_follows_r11: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    p_valid_drops_r11: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);
    p_hold_idle_r11: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(dest_out));
    p_reset_clear_r12: assert property (@(posedge clk)
        rst |=> (!out_valid && dest_out == '0));
    p_legacy_upper_r9: assert property (@(posedge clk) disable iff (rst)
        (in_valid && enc_sel == 2'd0) |=>
            dest_out[DATA_W-1:128] == $past(dest_in[DATA_W-1:128]));
    p_upper_clear_r3: assert property (@(posedge clk) disable iff (rst)
        (in_valid && enc_sel == 2'd1 && vlen_sel == 2'd0) |=>
            dest_out[DATA_W-1:128] == '0);
endmodule

// File: tb/psub_sat_unit_test.sv
module psub_sat_unit_test;

    logic         clk = 1'b0;
    logic         rst;
    logic         in_valid;
    logic [511:0] dest_in, src_a, src_b;
    logic         lane_word;
    logic [1:0]   vlen_sel, enc_sel;
    logic [63:0]  mask_bits;
    logic         mask_en, mask_zero;
    logic         out_valid;
    logic [511:0] dest_out;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    psub_sat_unit uut (
        .clk(clk), .rst(rst), .in_valid(in_valid),
        .dest_in(dest_in), .src_a(src_a), .src_b(src_b),
        .lane_word(lane_word), .vlen_sel(vlen_sel), .enc_sel(enc_sel),
        .mask_bits(mask_bits), .mask_en(mask_en), .mask_zero(mask_zero),
        .out_valid(out_valid), .dest_out(dest_out)
    );

    typedef struct packed {
        logic        lw;
        logic [1:0]  vl;
        logic [1:0]  enc;
        logic        me;
        logic        mz;
        logic [63:0] mask;
        logic [31:0] seed;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 2'd2, 2'd1, 1'b0, 1'b0, 64'h0, 32'h11},                 // R1 R3
        '{1'b1, 2'd2, 2'd1, 1'b0, 1'b0, 64'h0, 32'h22},                 // R2 R3
        '{1'b0, 2'd0, 2'd1, 1'b0, 1'b0, 64'h0, 32'h33},                 // R3
        '{1'b1, 2'd1, 2'd1, 1'b0, 1'b0, 64'h0, 32'h44},                 // R3
        '{1'b0, 2'd2, 2'd2, 1'b1, 1'b0, 64'hA5A5_0F0F_3C3C_9999, 32'h55}, // R4 R5
        '{1'b1, 2'd2, 2'd2, 1'b1, 1'b1, 64'h0000_0000_C3C3_5A5A, 32'h66}, // R4 R6
        '{1'b0, 2'd1, 2'd2, 1'b1, 1'b1, 64'h0000_0000_F0F0_0FF0, 32'h77}, // R6
        '{1'b1, 2'd0, 2'd2, 1'b1, 1'b0, 64'hFFFF_FFFF_FFFF_FF35, 32'h88}, // R5 R8
        '{1'b0, 2'd2, 2'd2, 1'b0, 1'b1, 64'h0,                 32'h99}, // R7
        '{1'b0, 2'd1, 2'd1, 1'b0, 1'b1, 64'h1234_5678_0000_0001, 32'hAA}, // R7
        '{1'b0, 2'd0, 2'd0, 1'b0, 1'b0, 64'h0, 32'hBB},                 // R9
        '{1'b1, 2'd0, 2'd0, 1'b1, 1'b1, 64'h0, 32'hCC},                 // R9 R7
        '{1'b0, 2'd2, 2'd0, 1'b0, 1'b0, 64'h0, 32'hDD},                 // R10
        '{1'b1, 2'd1, 2'd3, 1'b0, 1'b0, 64'h0, 32'hEE},                 // R10
        '{1'b0, 2'd3, 2'd1, 1'b0, 1'b0, 64'h0, 32'hF1},                 // R10
        '{1'b1, 2'd3, 2'd2, 1'b1, 1'b0, 64'h0000_0000_0000_00A6, 32'hF2}  // R10 R5
    };
    localparam string TAGS [NV] = '{
        "R1", "R2", "R3", "R3", "R5", "R6", "R6", "R8",
        "R7", "R7", "R9", "R9", "R10", "R10", "R10", "R10"
    };

    function automatic logic [511:0] gen(input logic [31:0] seed, input int salt);
        logic [511:0] v;
        logic [31:0]  x = seed ^ (32'h9E37_79B1 * salt);
        for (int i = 0; i < 16; i++) begin
            x = x * 32'd1664525 + 32'd1013904223;
            v[i*32 +: 32] = x ^ (x >> 13);
        end
        return v;
    endfunction

    // reference from the requirements
    function automatic logic [511:0] model(
        input logic [511:0] d, input logic [511:0] a, input logic [511:0] b,
        input logic lw, input logic [1:0] vl, input logic [1:0] enc,
        input logic me, input logic mz, input logic [63:0] mask);
        logic [511:0] r;
        logic [511:0] first;
        bit legacy_s = (enc == 2'd0) || (enc == 2'd3);
        bit use_mask = (enc == 2'd2) && me;
        int vbits = legacy_s ? 128 : (vl == 2'd1 ? 256 : (vl == 2'd2 ? 512 : 128));
        first = legacy_s ? d : a;
        if (lw) begin
            for (int j = 0; j < 32; j++) begin
                logic [15:0] x = first[j*16 +: 16];
                logic [15:0] y = b[j*16 +: 16];
                if (j*16 >= vbits)
                    r[j*16 +: 16] = legacy_s ? d[j*16 +: 16] : 16'h0;
                else if (use_mask && !mask[j])
                    r[j*16 +: 16] = mz ? 16'h0 : d[j*16 +: 16];
                else
                    r[j*16 +: 16] = (x < y) ? 16'h0 : x - y;
            end
        end else begin
            for (int j = 0; j < 64; j++) begin
                logic [7:0] x = first[j*8 +: 8];
                logic [7:0] y = b[j*8 +: 8];
                if (j*8 >= vbits)
                    r[j*8 +: 8] = legacy_s ? d[j*8 +: 8] : 8'h0;
                else if (use_mask && !mask[j])
                    r[j*8 +: 8] = mz ? 8'h0 : d[j*8 +: 8];
                else
                    r[j*8 +: 8] = (x < y) ? 8'h0 : x - y;
            end
        end
        return r;
    endfunction

    task automatic check(input string tag, input logic [511:0] act, input logic [511:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic apply(input logic [511:0] d, input logic [511:0] a, input logic [511:0] b,
                         input logic lw, input logic [1:0] vl, input logic [1:0] enc,
                         input logic me, input logic mz, input logic [63:0] m);
        @(negedge clk);
        dest_in = d; src_a = a; src_b = b; lane_word = lw; vlen_sel = vl;
        enc_sel = enc; mask_en = me; mask_zero = mz; mask_bits = m; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    initial begin
        #(4 * 150000);
        if (!finished) begin
            n_errors++;
            n_checks++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        logic [511:0] d, a, b, r1, r2;
        rst = 1'b1; in_valid = 1'b0; dest_in = '0; src_a = '0; src_b = '0;
        lane_word = 1'b0; vlen_sel = 2'd0; enc_sel = 2'd0; mask_bits = '0;
        mask_en = 1'b0; mask_zero = 1'b0;
        repeat (3) @(negedge clk);
        // R12: reset state
        check("R12 reset data", dest_out, '0);
        check("R12 reset valid", {511'b0, out_valid}, '0);
        rst = 1'b0;

        // table walk
        for (int i = 0; i < NV; i++) begin
            d = gen(VECS[i].seed, 1);
            a = gen(VECS[i].seed, 2);
            b = gen(VECS[i].seed, 3);
            apply(d, a, b, VECS[i].lw, VECS[i].vl, VECS[i].enc,
                  VECS[i].me, VECS[i].mz, VECS[i].mask);
            check(TAGS[i], dest_out,
                  model(d, a, b, VECS[i].lw, VECS[i].vl, VECS[i].enc,
                        VECS[i].me, VECS[i].mz, VECS[i].mask));
        end

        // R1: byte clamp and exact difference
        a = '0; b = '0;
        a[7:0] = 8'h10; b[7:0] = 8'h20;
        a[15:8] = 8'h20; b[15:8] = 8'h10;
        a[23:16] = 8'h7F; b[23:16] = 8'h7F;
        a[31:24] = 8'hFF; b[31:24] = 8'h00;
        apply('1, a, b, 1'b0, 2'd0, 2'd1, 1'b0, 1'b0, '0);
        check("R1 byte lanes", dest_out, {480'b0, 32'hFF00_1000});

        // R2: word lanes, no cross-lane borrow, clamp
        a = '0; b = '0;
        a[15:0] = 16'h0100; b[15:0] = 16'h0001;
        a[31:16] = 16'h0001; b[31:16] = 16'h0002;
        a[47:32] = 16'h0000; b[47:32] = 16'h0000;
        apply('0, a, b, 1'b1, 2'd0, 2'd1, 1'b0, 1'b0, '0);
        check("R2 word lanes", dest_out, {496'b0, 16'h00FF});

        // R11: valid pulse and hold
        @(negedge clk);
        check("R11 valid low after pulse", {511'b0, out_valid}, '0);
        r1 = dest_out;
        src_b = '1;
        repeat (3) @(negedge clk);
        check("R11 hold while idle", dest_out, r1);
        @(negedge clk);
        in_valid = 1'b1;
        #1;
        check("R11 no early update", {511'b0, out_valid}, '0);
        @(negedge clk);
        in_valid = 1'b0;
        check("R11 valid one cycle later", {511'b0, out_valid}, 512'd1);

        // R8: junk in mask bits beyond KL
        d = gen(32'h501, 1); a = gen(32'h501, 2); b = gen(32'h501, 3);
        apply(d, a, b, 1'b0, 2'd0, 2'd2, 1'b1, 1'b0, 64'h0000_0000_0000_5A5A);
        r1 = dest_out;
        apply(d, a, b, 1'b0, 2'd0, 2'd2, 1'b1, 1'b0, 64'hFFFF_FFFF_FFFF_5A5A);
        check("R8 upper mask ignored", dest_out, r1);

        // R7: mask ignored when mask_en=0
        apply(d, a, b, 1'b1, 2'd2, 2'd2, 1'b0, 1'b1, 64'h0);
        check("R7 mask disabled", dest_out,
              model(d, a, b, 1'b1, 2'd2, 2'd1, 1'b0, 1'b0, '0));

        // R9: src_a ignored in legacy style
        apply(d, a, b, 1'b0, 2'd0, 2'd0, 1'b0, 1'b0, '0);
        r1 = dest_out;
        apply(d, ~a, b, 1'b0, 2'd0, 2'd0, 1'b0, 1'b0, '0);
        r2 = dest_out;
        check("R9 src_a ignored", r2, r1);
        check("R9 upper kept", {r2[511:128], 128'b0}, {d[511:128], 128'b0});

        // R4/R6: all lanes masked off with zeroing, byte 512
        apply(d, a, b, 1'b0, 2'd2, 2'd2, 1'b1, 1'b1, 64'h0);
        check("R6 all zeroed", dest_out, '0);
        apply(d, a, b, 1'b0, 2'd2, 2'd2, 1'b1, 1'b0, 64'h0);
        check("R5 all merged", dest_out, d);
        apply(d, a, b, 1'b0, 2'd2, 2'd2, 1'b1, 1'b1, '1);
        check("R4 all written", dest_out,
              model(d, a, b, 1'b0, 2'd2, 2'd1, 1'b0, 1'b0, '0));

        // R12: synchronous reset mid-run
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R12 reset clears", dest_out, '0);

        finished = 1'b1;
        $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule